// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Model

This block is a synthesizable behavioural model of a static RAM with two data ports, one for reads and one for writes, and a single address bus shared between them. The model runs on a beat clock at twice the command rate. Each beat stands for one edge of the true or the complementary input clock. Beats alternate between command beats and address/data beats. A read burst and a write burst may be in flight at the same time. Each one moves four 18-bit words, one per beat.

A command beat samples both port selects. A read takes its line address on the command beat. A write takes its line address on the next beat, so the two addresses arrive on alternate edges of the same bus. The four write words follow on the next four beats. Each write word carries a per-lane write mask for its two 9-bit lanes. The four read words leave on a dedicated output after a fixed latency, which is set by a parameter. A valid flag marks them and stands in for the output enable of a three-state driver.

Data moves on a fixed schedule, so neither port has back-pressure. A port accepts at most one command every two command beats. The host aligns its commands to the `cmd_beat` pin. The storage array is a parameterized register array. Its depth is set by `ADDR_W`, and a full-size device uses 17 address bits. Reset clears the pipeline and leaves the array contents alone.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset is released, the first beat is a command beat, and beats then alternate between command beats and other beats. `cmd_beat` is high during the beat whose closing clock edge is a command edge.
- R2: A read is accepted when `rd_sel_n` is low at a command edge and the read port is free. The line address is taken from `addr` at that same edge. A low `rd_sel_n` at a non-command edge does nothing.
- R3: A write is accepted when `wr_sel_n` is low at a command edge and the write port is free. The line address is taken from `addr` at the next edge. Words 0 to 3 are taken from `wdata` at the four edges after that. A low `wr_sel_n` at a non-command edge does nothing.
- R4: Let t be the edge that accepts a read. Word k of its line (k = 0..3, word 0 first) is on `rd_data` with `rd_valid` high in the beat after edge t+RD_LAT+k. `rd_valid` is high for exactly four beats per burst. Two reads four beats apart give eight contiguous valid beats. Raising `rd_sel_n` after a read command does not cut its burst short.
- R5: A low `wmask_n[0]` writes bits 8:0 of the word on that beat, and a low `wmask_n[1]` writes bits 17:9. A lane whose mask bit is high keeps its stored value.
- R6: A port is busy for the command edge that directly follows one it accepted. A command on that port at that edge is ignored, together with its address, and the write data beats that would follow it.
- R7: A read returns the line exactly as stored before its command edge. Write words stored at that edge or later do not appear in it.
- R8: Whenever `rd_valid` is low, `rd_data` is all zeros.
- R9: Asserting reset drops `rd_valid` at once and discards any read still in the pipeline. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset of all pipeline state |
| rd_sel_n | input | 1 | Active-low read request, sampled on command edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on command edges |
| addr | input | ADDR_W | Shared line address: read address on the command edge, write address on the edge after |
| wdata | input | 18 | Write word for the current data beat |
| wmask_n | input | 2 | Active-low lane write enables for `wdata` (bit 0: bits 8:0, bit 1: bits 17:9) |
| rd_data | output | 18 | Read word, zero when not valid |
| rd_valid | output | 1 | Read word valid (output-enable stand-in) |
| cmd_beat | output | 1 | High in the beat that ends on a command edge |

## Verification
Every result is due at a fixed edge. A write's words land on edges t+2 to t+5 after its command edge t. Read word k appears after edge t+RD_LAT+k, where t is the read's command edge. The bench builds its expected queue by walking the planned stimulus beat by beat. At each beat it applies the acceptance rule, reads the reference memory before that beat's write word is applied, and stamps each expected word with its due edge. A monitor samples 3 ns after every edge. It then requires either the head-of-queue word, if that word is due at this edge, or an idle all-zero output. A word that is early, late, missing or extra therefore fails at the exact edge where it goes wrong.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int WORD_W  = 18;
  localparam int LANE_W  = 9;
  localparam int N_LANES = WORD_W / LANE_W;
  localparam int BURST   = 4;
  localparam int IDX_W   = $clog2(BURST);
  localparam int LINE_W  = BURST * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/qdr_cmd_ctrl.sv
module qdr_cmd_ctrl
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_beat,
  output logic              rd_launch,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_line,
  output logic [IDX_W-1:0]  wr_word
);
  logic              phase_q;
  logic              rd_recent_q, wr_recent_q;
  logic              wr_cmd_q;
  logic              burst_act_q;
  logic [IDX_W-1:0]  burst_idx_q;
  logic [ADDR_W-1:0] burst_line_q;
  logic              rd_acc, wr_acc;

  assign cmd_beat = ~phase_q;
  assign rd_acc   = cmd_beat & ~rd_sel_n & ~rd_recent_q;
  assign wr_acc   = cmd_beat & ~wr_sel_n & ~wr_recent_q;

  // beat phase and per-port pacing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= 1'b0;
      rd_recent_q <= 1'b0;
      wr_recent_q <= 1'b0;
      wr_cmd_q    <= 1'b0;
    end else begin
      phase_q  <= ~phase_q;
      wr_cmd_q <= wr_acc;
      if (cmd_beat) begin
        rd_recent_q <= rd_acc;
        wr_recent_q <= wr_acc;
      end
    end
  end

  // write burst sequencer: address on the beat after the command, then four data beats
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act_q  <= 1'b0;
      burst_idx_q  <= '0;
      burst_line_q <= '0;
    end else if (wr_cmd_q) begin
      burst_act_q  <= 1'b1;
      burst_idx_q  <= '0;
      burst_line_q <= addr;
    end else if (burst_act_q) begin
      burst_idx_q <= burst_idx_q + 1'b1;
      if (burst_idx_q == IDX_W'(BURST - 1)) burst_act_q <= 1'b0;
    end
  end

  assign rd_launch = rd_acc;
  assign wr_en     = burst_act_q;
  assign wr_line   = burst_line_q;
  assign wr_word   = burst_idx_q;

  AST_WR_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_act_q) |=> burst_act_q ##1 burst_act_q ##1 burst_act_q); // R3
endmodule

// File: rtl/qdr_array.sv
module qdr_array
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_line,
  input  logic [IDX_W-1:0]   wr_word,
  input  word_t              wr_data,
  input  logic [N_LANES-1:0] wr_lane_en,
  input  logic [ADDR_W-1:0]  rd_line_addr,
  output line_t              rd_line
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOTS  = DEPTH * BURST;
  localparam int SLOT_W = ADDR_W + IDX_W;

  logic [SLOT_W-1:0] wslot;
  assign wslot = {wr_line, wr_word};

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane_en[g]) mem[wslot] <= wr_data[g*LANE_W +: LANE_W];
    end

    for (genvar w = 0; w < BURST; w++) begin : g_word
      assign rd_line[w*WORD_W + g*LANE_W +: LANE_W] = mem[{rd_line_addr, IDX_W'(w)}];
    end
  end

  AST_WR_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word != '0) |-> ($past(wr_en) && wr_word == $past(wr_word) + 1'b1)); // R3
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
  import qdr_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  line_t line_in,
  output word_t q,
  output logic  q_valid
);
  localparam int LAST = RD_LAT - 1;

  logic             st_v [RD_LAT];
  line_t            st_d [RD_LAT];
  line_t            hold_q;
  logic [IDX_W-1:0] nxt_q;

  // fixed-latency delay line holding the line snapshot taken at the command edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_LAT; i++) st_v[i] <= 1'b0;
    end else begin
      st_v[0] <= launch;
      for (int i = 1; i < RD_LAT; i++) st_v[i] <= st_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    st_d[0] <= line_in;
    for (int i = 1; i < RD_LAT; i++) st_d[i] <= st_d[i-1];
  end

  // serializer: one word per beat, word 0 first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
      hold_q  <= '0;
      nxt_q   <= '0;
    end else if (st_v[LAST]) begin
      q       <= st_d[LAST][WORD_W-1:0];
      q_valid <= 1'b1;
      hold_q  <= st_d[LAST];
      nxt_q   <= IDX_W'(1);
    end else if (nxt_q != '0) begin
      q       <= hold_q[nxt_q*WORD_W +: WORD_W];
      q_valid <= 1'b1;
      nxt_q   <= nxt_q + 1'b1;
    end else begin
      q       <= '0;
      q_valid <= 1'b0;
    end
  end

  AST_BURST_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |=> q_valid ##1 q_valid ##1 q_valid); // R4
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [17:0]       wdata,
  input  logic [1:0]        wmask_n,
  output logic [17:0]       rd_data,
  output logic              rd_valid,
  output logic              cmd_beat
);
  logic              rd_launch;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_line;
  logic [IDX_W-1:0]  wr_word;
  line_t             rd_line;
  word_t             q;
  logic              q_valid;

  qdr_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .cmd_beat(cmd_beat), .rd_launch(rd_launch),
    .wr_en(wr_en), .wr_line(wr_line), .wr_word(wr_word)
  );

  qdr_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_line(wr_line),
    .wr_word(wr_word), .wr_data(wdata), .wr_lane_en(~wmask_n),
    .rd_line_addr(addr), .rd_line(rd_line)
  );

  qdr_rd_pipe #(.RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .launch(rd_launch), .line_in(rd_line),
    .q(q), .q_valid(q_valid)
  );

  assign rd_data  = q;
  assign rd_valid = q_valid;

  AST_Q_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0); // R8

  AST_LAUNCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_launch |=> !rd_launch ##1 !rd_launch ##1 !rd_launch); // R6
endmodule

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb;
  localparam int AW  = 4;
  localparam int LAT = 2;
  localparam int NB  = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [17:0]   wdata;
  logic [1:0]    wmask_n;
  logic [17:0]   rd_data;
  logic          rd_valid, cmd_beat;

  always #5 clk = ~clk;

  qdr_burst_sram #(.ADDR_W(AW), .RD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wmask_n(wmask_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .cmd_beat(cmd_beat)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic          s_rs [NB];
  logic          s_ws [NB];
  logic [AW-1:0] s_a  [NB];
  logic [17:0]   s_d  [NB];
  logic [1:0]    s_m  [NB];
  string         s_tag[NB];
  logic [17:0]   bm [(1<<AW)*4];

  int          exp_due[$];
  logic [17:0] exp_val[$];
  string       exp_tag[$];
  int          cur_edge;
  bit          run_on = 0;

  function automatic logic [17:0] mk(int base, int k);
    return 18'(base * 1111 + k * 37 + 18'h2A5A4);
  endfunction

  task automatic check(bit ok, string tag, logic [17:0] got, logic [17:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", tag, got, expv, cur_edge);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < NB; i++) begin
      s_rs[i] = 1'b1; s_ws[i] = 1'b1; s_a[i] = '0;
      s_d[i] = '0; s_m[i] = 2'b11; s_tag[i] = "";
    end
  endtask

  task automatic plan_wr(int b, int a, int base, logic [7:0] m);
    s_ws[b] = 1'b0;
    s_a[b+1] = AW'(a);
    for (int k = 0; k < 4; k++) begin
      s_d[b+2+k] = mk(base, k);
      s_m[b+2+k] = m[2*k +: 2];
    end
  endtask

  task automatic plan_rd(int b, int a, string tag);
    s_rs[b] = 1'b0;
    s_a[b] = AW'(a);
    s_tag[b] = tag;
  endtask

  // reference walk: acceptance rule, snapshot before the beat's write word, due edges
  task automatic build_expect(int n);
    int  d_line[NB+8];
    int  d_idx[NB+8];
    bit  rr = 0, wr = 0;
    for (int i = 0; i < NB + 8; i++) begin d_line[i] = -1; d_idx[i] = 0; end
    for (int b = 0; b < n; b++) begin
      if (b % 2 == 0) begin
        bit ra = !s_rs[b] && !rr;
        bit wa = !s_ws[b] && !wr;
        if (ra) begin
          for (int k = 0; k < 4; k++) begin
            exp_due.push_back(b + LAT + k);
            exp_val.push_back(bm[int'(s_a[b])*4 + k]);
            exp_tag.push_back(s_tag[b]);
          end
        end
        if (wa) begin
          for (int k = 0; k < 4; k++) begin
            d_line[b+2+k] = int'(s_a[b+1]);
            d_idx[b+2+k] = k;
          end
        end
        rr = ra; wr = wa;
      end
      if (d_line[b] >= 0) begin
        if (!s_m[b][0]) bm[d_line[b]*4 + d_idx[b]][8:0]  = s_d[b][8:0];
        if (!s_m[b][1]) bm[d_line[b]*4 + d_idx[b]][17:9] = s_d[b][17:9];
      end
    end
  endtask

  task automatic drive_idle();
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0; wdata = '0; wmask_n = 2'b11;
  endtask

  // driver: called at a negedge, drives beat b before edge b
  task automatic run_sched(int n);
    build_expect(n);
    cur_edge = -1;
    run_on = 1;
    for (int b = 0; b < n; b++) begin
      if (b < 4) check(cmd_beat == (b % 2 == 0), "R1 cmd_beat phase",
                       18'(cmd_beat), 18'(b % 2 == 0));
      rd_sel_n = s_rs[b]; wr_sel_n = s_ws[b]; addr = s_a[b];
      wdata = s_d[b]; wmask_n = s_m[b];
      @(negedge clk);
    end
    run_on = 0;
    drive_idle();
  endtask

  // monitor: samples 3 ns after each edge
  always @(posedge clk) begin
    #3;
    if (run_on) begin
      cur_edge++;
      if (exp_due.size() > 0 && exp_due[0] == cur_edge) begin
        check(rd_valid === 1'b1 && rd_data === exp_val[0],
              $sformatf("%s R4 word", exp_tag[0]), rd_data, exp_val[0]);
        void'(exp_due.pop_front());
        void'(exp_val.pop_front());
        void'(exp_tag.pop_front());
      end else begin
        check(rd_valid === 1'b0 && rd_data === 18'h0,
              "R8/R9 idle output", {rd_valid, rd_data[16:0]}, 18'h0);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === 18'h0, "R9 reset state", rd_data, 18'h0);
    check(cmd_beat === 1'b1, "R1 reset phase", 18'(cmd_beat), 18'h1);
    rst_n = 1'b1;

    // phase A
    clear_stim();
    plan_wr(0, 3, 10, 8'h00);
    plan_wr(4, 5, 20, 8'h00);
    plan_rd(8, 3, "R2 R3 R7 same-beat write");
    plan_wr(8, 3, 30, 8'b00_11_10_01);       // R5 masks per word
    plan_rd(10, 5, "R6 busy read");          // rejected
    s_ws[10] = 1'b0; s_a[11] = AW'(5);       // rejected write
    plan_rd(12, 3, "R7 partial snapshot");
    plan_rd(16, 3, "R5 masked lanes");
    plan_rd(20, 5, "R6 ignored write");
    plan_rd(24, 3, "R4 back-to-back");
    s_rs[27] = 1'b0; s_a[27] = AW'(5);       // R2 odd-beat read ignored
    plan_wr(28, 9, 40, 8'h00);
    s_ws[31] = 1'b0;                         // R3 odd-beat write ignored
    plan_wr(32, 10, 50, 8'h00);
    plan_rd(32, 5, "R2 concurrent read");
    plan_rd(36, 9, "R3 write burst");
    plan_rd(40, 10, "R3 second write");
    plan_rd(44, 3, "R9 dropped");            // still in flight at reset
    run_sched(46);

    // reset with a burst in flight
    rst_n = 1'b0;
    #1;
    check(rd_valid === 1'b0, "R9 reset drops valid", 18'(rd_valid), 18'h0);
    exp_due.delete(); exp_val.delete(); exp_tag.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // phase B: array retained
    clear_stim();
    plan_rd(0, 10, "R9 retained");
    plan_rd(4, 9, "R9 retained");
    plan_rd(8, 3, "R9 R5 retained");
    run_sched(16);
    check(exp_due.size() == 0, "R4 missing words", 18'(exp_due.size()), 18'h0);
    finish_up();
  end
endmodule